// File: doc/BRIEF.md
# Serial Register Port with Time Snapshot

This block is the serial-bus slave front end of a 64-register space. A host selects it by pulling the active-low select low. It then clocks in one header byte followed by any number of data bytes. The header carries a direction bit and a register address. Later bytes are either written to consecutive registers or shifted out from them. The serial clock, select and data inputs arrive already synchronized to the system clock. The block finds serial-clock edges by comparing each sample with the one before it.

The lowest registers hold time-of-day values. Separate counter logic keeps these values running. The block keeps its own copy of them, and reads of those addresses return the copy. The copy follows the live counters every cycle while the select is high. It freezes for as long as the select is low, so a multi-byte read returns one consistent instant. All other addresses are read combinationally from the surrounding register file through `rd_addr`/`rd_data`.

Write data flows out as a single-cycle `wr_valid` beat. There is no ready: the host owns the serial clock and cannot be stalled. The sink must therefore accept every beat in the cycle it appears. `rd_data` must be valid in the same cycle as `rd_addr`. When a byte read from the flag register has been fully clocked out, `rd_flag` pulses for one cycle so that flag-clearing logic can act on it.

Top module: `serial_reg_port`

## Requirements
- R1: After reset `miso_oe`, `wr_valid` and `rd_flag` are all 0.
- R2: The first byte after the select falls is the header, sampled MSB first. Header bit 7 = 1 selects write and 0 selects read. Bits 5:0 are the register index, and bit 6 is ignored.
- R3: In a write, each complete data byte after the header produces exactly one single-cycle `wr_valid` with `wr_addr` and `wr_data` (MSB received first). No write appears while the select is high.
- R4: After each data byte the register index increments by one, wrapping from 63 to 0, for both reads and writes.
- R5: Read data is driven on `miso` MSB first. It changes only in the cycle after a detected falling serial-clock edge, and the host samples it at the following rising edge.
- R6: `miso_oe` stays 0 during the header, throughout a write and while the select is high. In a read it goes to 1 at the first falling edge after the header.
- R7: R2 to R6 hold with the serial clock idling low as well as idling high; data is always sampled on rising edges.
- R8: Indexes below NTIME (8) return the snapshot copy of the live time bytes. All other indexes return `rd_data` at `rd_addr` = index.
- R9: The snapshot copies `live_time` in every cycle that the select is high. It holds its value in every cycle that the select is low.
- R10: `rd_flag` pulses for exactly one cycle when the eighth rising edge of a data byte read from index FLAG_ADDR (15) is seen. It never pulses for other indexes or in a write.
- R11: Raising the select ends the transfer. A partial byte is discarded and writes nothing, and the next transfer starts with a fresh header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select, synchronized |
| sck | input | 1 | Serial clock, synchronized |
| mosi | input | 1 | Serial data from host, synchronized |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the `miso` pad (0 = high impedance) |
| live_time | input | NTIME*8 | Live time bytes, byte i at bits 8i+7:8i |
| rd_addr | output | ADDR_W | Register index being fetched for a read |
| rd_data | input | 8 | Register file data for `rd_addr`, same cycle |
| wr_valid | output | 1 | Write beat, one cycle, no back-pressure |
| wr_addr | output | ADDR_W | Write register index |
| wr_data | output | 8 | Write data |
| rd_flag | output | 1 | One-cycle pulse after the flag register byte has been read |

## Verification
The hardest condition to reach from the ports is a snapshot that stays frozen while the live counters keep moving during a long read. The bench reaches it by changing `live_time` on every serial bit of an eight-byte read that starts at index 0. Every byte must match the value present before the select fell, and a follow-up read must show the new value. Sweeping single-byte reads over all 64 indexes in both idle polarities covers the edge between snapshot and register file and the one flag index. An aborted write tests that a partial byte leaves no trace.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int BYTE_W = 8;
  localparam int HDR_ADDR_W = 7;

  typedef struct packed {
    logic                  wr;
    logic [HDR_ADDR_W-1:0] idx;
  } hdr_t;
endpackage

// File: rtl/srp_edges.sv
module srp_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  output logic rise,
  output logic fall
);
  logic sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  assign rise = !cs_n && sck && !sck_q;
  assign fall = !cs_n && !sck && sck_q;
endmodule

// File: rtl/srp_snapshot.sv
module srp_snapshot #(
  parameter int ADDR_W = 6,
  parameter int NTIME  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic [NTIME*8-1:0]  live_time,
  input  logic [ADDR_W-1:0]   idx,
  input  logic [7:0]          ext_data,
  output logic [NTIME*8-1:0]  snap_flat,
  output logic [7:0]          rd_byte
);
  logic [7:0] snap [NTIME];

  for (genvar g = 0; g < NTIME; g++) begin : g_snap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    snap[g] <= 8'h00;
      else if (cs_n) snap[g] <= live_time[g*8 +: 8];
    end
    assign snap_flat[g*8 +: 8] = snap[g];
  end

  always_comb begin
    rd_byte = ext_data;
    for (int i = 0; i < NTIME; i++) begin
      if (idx == ADDR_W'(i)) rd_byte = snap[i];
    end
  end
endmodule

// File: rtl/srp_xfer.sv
module srp_xfer
  import srp_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int FLAG_ADDR = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic              rise,
  input  logic              fall,
  input  logic [7:0]        rd_byte,
  output logic [ADDR_W-1:0] idx,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              miso,
  output logic              miso_oe,
  output logic              rd_flag
);
  logic [2:0]        bit_cnt;
  logic              in_hdr;
  logic              is_wr;
  logic [6:0]        shin;
  logic [7:0]        pre_byte;
  logic [ADDR_W-1:0] pre_idx;
  logic [7:0]        tx_sh;
  logic [ADDR_W-1:0] sh_idx;
  logic              fetch_pend;
  logic [7:0]        byte_in;
  hdr_t              hdr;
  logic              byte_done;

  assign byte_in   = {shin, mosi};
  assign hdr       = hdr_t'(byte_in);
  assign byte_done = rise && (bit_cnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      in_hdr     <= 1'b1;
      is_wr      <= 1'b0;
      shin       <= '0;
      idx        <= '0;
      pre_byte   <= '0;
      pre_idx    <= '0;
      tx_sh      <= '0;
      sh_idx     <= '0;
      fetch_pend <= 1'b0;
      miso_oe    <= 1'b0;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      rd_flag    <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      rd_flag  <= 1'b0;
      if (cs_n) begin
        bit_cnt    <= '0;
        in_hdr     <= 1'b1;
        miso_oe    <= 1'b0;
        fetch_pend <= 1'b0;
      end else begin
        if (fetch_pend) begin
          pre_byte   <= rd_byte;
          pre_idx    <= idx;
          idx        <= idx + 1'b1;
          fetch_pend <= 1'b0;
        end
        if (rise) begin
          shin    <= byte_in[6:0];
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (byte_done) begin
          if (in_hdr) begin
            in_hdr     <= 1'b0;
            is_wr      <= hdr.wr;
            idx        <= hdr.idx[ADDR_W-1:0];
            fetch_pend <= !hdr.wr;
          end else if (is_wr) begin
            wr_valid <= 1'b1;
            wr_addr  <= idx;
            wr_data  <= byte_in;
            idx      <= idx + 1'b1;
          end else if (miso_oe && sh_idx == ADDR_W'(FLAG_ADDR)) begin
            rd_flag <= 1'b1;
          end
        end
        if (fall && !in_hdr && !is_wr) begin
          if (bit_cnt == 3'd0) begin
            tx_sh      <= pre_byte;
            sh_idx     <= pre_idx;
            miso_oe    <= 1'b1;
            fetch_pend <= 1'b1;
          end else begin
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign miso = miso_oe ? tx_sh[7] : 1'b0;
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int ADDR_W    = 6,
  parameter int NTIME     = 8,
  parameter int FLAG_ADDR = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sck,
  input  logic               mosi,
  output logic               miso,
  output logic               miso_oe,
  input  logic [NTIME*8-1:0] live_time,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic [7:0]         rd_data,
  output logic               wr_valid,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [7:0]         wr_data,
  output logic               rd_flag
);
  logic               sck_rise;
  logic               sck_fall;
  logic [7:0]         rd_byte;
  logic [NTIME*8-1:0] snap_flat;

  srp_edges u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .cs_n (cs_n),
    .sck  (sck),
    .rise (sck_rise),
    .fall (sck_fall)
  );

  srp_snapshot #(.ADDR_W(ADDR_W), .NTIME(NTIME)) u_snap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .live_time(live_time),
    .idx      (rd_addr),
    .ext_data (rd_data),
    .snap_flat(snap_flat),
    .rd_byte  (rd_byte)
  );

  srp_xfer #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_xfer (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .mosi    (mosi),
    .rise    (sck_rise),
    .fall    (sck_fall),
    .rd_byte (rd_byte),
    .idx     (rd_addr),
    .wr_valid(wr_valid),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .miso    (miso),
    .miso_oe (miso_oe),
    .rd_flag (rd_flag)
  );
endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
  parameter int NTIME = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_n,
  input logic               sck_fall,
  input logic               miso,
  input logic               miso_oe,
  input logic               wr_valid,
  input logic               rd_flag,
  input logic [NTIME*8-1:0] snap_flat
);
  assert_hiz_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !miso_oe);

  assert_no_idle_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !wr_valid);

  assert_flag_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flag |=> !rd_flag);

  assert_flag_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !rd_flag);

  assert_miso_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && !sck_fall && !cs_n) |=> $stable(miso));

  assert_snap_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> $stable(snap_flat));
endmodule

bind serial_reg_port srp_checker #(.NTIME(NTIME)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .sck_fall (sck_fall),
  .miso     (miso),
  .miso_oe  (miso_oe),
  .wr_valid (wr_valid),
  .rd_flag  (rd_flag),
  .snap_flat(snap_flat)
);

// File: tb/sim_serial_reg_port.sv
`timescale 1ns/1ps
module sim_serial_reg_port;
  localparam int ADDR_W = 6;
  localparam int NTIME  = 8;
  localparam int HALF   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso, miso_oe, wr_valid, rd_flag;
  logic [NTIME*8-1:0] live_time;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic [7:0] base = 8'h00;

  int tests = 0;
  int fails = 0;
  int wn = 0;
  int fn = 0;
  logic [ADDR_W-1:0] wa [64];
  logic [7:0] wd [64];
  logic [7:0] txb [8];
  logic [7:0] rxb [8];
  logic churn = 1'b0;
  logic oe_hdr, oe_any;

  always #4 clk = ~clk;

  serial_reg_port u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .live_time(live_time),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_flag(rd_flag)
  );

  assign rd_data = {2'b00, rd_addr} * 8'd5 + 8'd17;
  always_comb begin
    for (int i = 0; i < NTIME; i++) live_time[i*8 +: 8] = base + 8'(i);
  end

  always @(posedge clk) begin
    if (wr_valid) begin
      wa[wn % 64] <= wr_addr;
      wd[wn % 64] <= wr_data;
      wn <= wn + 1;
    end
    if (rd_flag) fn <= fn + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitx(input int mode, input logic b, input bit hdr, output logic r);
    if (mode == 3) sck = 1'b0;
    mosi = b;
    repeat (HALF) @(negedge clk);
    r = miso;
    if (miso_oe) begin
      oe_any = 1'b1;
      if (hdr) oe_hdr = 1'b1;
    end
    if (churn) base = base + 8'd3;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    if (mode == 0) sck = 1'b0;
  endtask

  // mode 0: clock idles low, mode 3: clock idles high; cut>0 sends only cut bits of byte 0
  task automatic xfer(input int mode, input logic [7:0] hdr, input int n, input int cut);
    logic r;
    oe_hdr = 1'b0;
    oe_any = 1'b0;
    sck = (mode == 3);
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int b = 7; b >= 0; b--) bitx(mode, hdr[b], 1'b1, r);
    for (int k = 0; k < n; k++) begin
      for (int b = 7; b >= 0; b--) begin
        if (cut == 0 || (7 - b) < cut) begin
          bitx(mode, txb[k][b], 1'b0, r);
          rxb[k][b] = r;
        end
      end
    end
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_rd(input int a, input logic [7:0] bs);
    if (a < NTIME) return bs + 8'(a);
    return 8'(a * 5 + 17);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int w0, f0, st;
    logic [7:0] bs;
    repeat (3) @(negedge clk);
    chk(miso_oe == 1'b0, "R1 oe", miso_oe, 0);
    chk(wr_valid == 1'b0, "R1 wr_valid", wr_valid, 0);
    chk(rd_flag == 1'b0, "R1 rd_flag", rd_flag, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(miso_oe == 1'b0, "R1 oe after release", miso_oe, 0);

    // R3 R4 R7: writes in both idle polarities, including wrap 63->0
    foreach (txb[i]) txb[i] = 8'h00;
    for (int m = 0; m <= 3; m += 3) begin
      for (int s = 0; s < 6; s++) begin
        st = (s == 5) ? 62 : s * 11;
        for (int k = 0; k < 3; k++) txb[k] = 8'(st * 3 + k * 29 + m);
        w0 = wn;
        xfer(m, 8'h80 | 8'(st), 3, 0);
        chk(wn - w0 == 3, "R3 write count", wn - w0, 3);
        chk(!oe_any, "R6 oe low in write", oe_any, 0);
        for (int k = 0; k < 3; k++) begin
          chk(wa[(w0 + k) % 64] == ADDR_W'((st + k) % 64), "R4 R7 write addr",
              wa[(w0 + k) % 64], (st + k) % 64);
          chk(wd[(w0 + k) % 64] == txb[k], "R3 R7 write data", wd[(w0 + k) % 64], txb[k]);
        end
      end
    end

    // R2: header bit 6 ignored
    txb[0] = 8'hA5;
    w0 = wn;
    xfer(0, 8'hC9, 1, 0);
    chk(wn - w0 == 1, "R2 bit6 count", wn - w0, 1);
    chk(wa[w0 % 64] == 6'd9, "R2 bit6 ignored addr", wa[w0 % 64], 9);

    // R5 R8 R10 R7: read sweep of every index in both polarities
    for (int m = 0; m <= 3; m += 3) begin
      for (int a = 0; a < 64; a++) begin
        base = 8'h30 + 8'(a);
        w0 = wn;
        f0 = fn;
        txb[0] = 8'hFF;
        xfer(m, 8'(a), 1, 0);
        chk(rxb[0] == exp_rd(a, 8'h30 + 8'(a)), "R5 R8 R7 read data", rxb[0],
            exp_rd(a, 8'h30 + 8'(a)));
        chk(fn - f0 == ((a == 15) ? 1 : 0), "R10 flag strobe", fn - f0, (a == 15) ? 1 : 0);
        chk(wn == w0, "R2 read writes nothing", wn - w0, 0);
        chk(!oe_hdr, "R6 oe low in header", oe_hdr, 0);
      end
    end

    // R4 R10: multi-byte read across the flag index
    base = 8'h10;
    f0 = fn;
    xfer(3, 8'd13, 4, 0);
    for (int k = 0; k < 4; k++)
      chk(rxb[k] == exp_rd(13 + k, 8'h10), "R4 burst read", rxb[k], exp_rd(13 + k, 8'h10));
    chk(fn - f0 == 1, "R10 burst flag", fn - f0, 1);

    // R4 R8: read wrap 62,63,0
    base = 8'h44;
    xfer(0, 8'd62, 3, 0);
    chk(rxb[0] == exp_rd(62, 8'h44), "R4 wrap 62", rxb[0], exp_rd(62, 8'h44));
    chk(rxb[1] == exp_rd(63, 8'h44), "R4 wrap 63", rxb[1], exp_rd(63, 8'h44));
    chk(rxb[2] == exp_rd(0, 8'h44), "R4 R8 wrap 0", rxb[2], exp_rd(0, 8'h44));

    // R9: snapshot frozen while live values move, then resumes
    base = 8'h50;
    churn = 1'b1;
    xfer(0, 8'd0, 8, 0);
    churn = 1'b0;
    for (int k = 0; k < 8; k++)
      chk(rxb[k] == 8'h50 + 8'(k), "R9 frozen snapshot", rxb[k], 8'h50 + 8'(k));
    bs = base;
    chk(bs != 8'h50, "R9 live moved", bs, 8'h50);
    xfer(3, 8'd2, 1, 0);
    chk(rxb[0] == bs + 8'd2, "R9 snapshot resumes", rxb[0], bs + 8'd2);

    // R11: aborted write leaves nothing, next transfer starts fresh
    txb[0] = 8'h3C;
    w0 = wn;
    xfer(0, 8'h87, 1, 5);
    chk(wn == w0, "R11 partial byte dropped", wn - w0, 0);
    chk(miso_oe == 1'b0, "R11 R6 oe after abort", miso_oe, 0);
    txb[0] = 8'h6B;
    xfer(3, 8'h87, 1, 0);
    chk(wn - w0 == 1, "R11 fresh header count", wn - w0, 1);
    chk(wa[w0 % 64] == 6'd7 && wd[w0 % 64] == 8'h6B, "R11 fresh header write",
        wd[w0 % 64], 8'h6B);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule